// File: doc/BRIEF.md
# Split Circular Serial Access Pointer

This block steers the word address of a serial access register that holds one row of a memory array. A transfer command loads a start address, called the tap, and each serial clock enable then moves the pointer one word on. In full-register mode the pointer covers the whole register and wraps from the top address to zero. In split mode the register is treated as two halves. The pointer climbs to the top of its current half and then jumps to a tap that was loaded separately for the other half. This lets a controller refill one half while serial traffic continues in the other.

Conventional transfers set the serial direction. A read transfer makes the serial port an output, and a write transfer makes it an input. Split transfers leave that direction alone. A split transfer also has no effect until a conventional transfer has happened since reset.

The storage is a dual-port word memory. One port faces the array side and is a plain word read/write port. The other port faces the serial side and is addressed by the pointer.

Top module: `serial_tap_sequencer`

## Requirements
- R1: After synchronous reset the pointer is 0, full-register mode is selected, the serial direction is input (`ser_dir_o`=0), and the half status is 0.
- R2: A conventional transfer (`xfer_kind` 2'b00 = read, 2'b01 = write) loads the pointer with `xfer_tap` on the next clock and selects full-register mode. A read sets `ser_dir_o` to 1 (output) and a write sets it to 0 (input).
- R3: In full-register mode each `sc_en` cycle with no transfer raises the pointer by one, and the top address wraps to 0. With neither `sc_en` nor a transfer, the pointer holds.
- R4: A split transfer (`xfer_kind` bit 1 set: 2'b10 = split read, 2'b11 = split write) issued before any conventional transfer since reset is ignored. The pointer, mode and direction are unchanged.
- R5: An accepted split transfer selects split mode and leaves `ser_dir_o` unchanged.
- R6: In split mode the pointer increments inside its half. A step from the top address of a half lands in the other half at the tap of the last accepted split transfer. A split transfer given in the same cycle as that step is the one used.
- R7: If no split tap is pending when the pointer leaves the top of a half, it enters the other half at that half's lowest address.
- R8: A split transfer whose tap has all low bits set (the last address of a half) is ignored.
- R9: A pending split tap is used by one half switch only. The next switch without a new split transfer goes to the lowest address of the other half.
- R10: `ptr_half_o` equals the most significant pointer bit, which gives the half the pointer is in.
- R11: A serial write happens when `sc_en` is high while the direction is input. It stores `ser_din` at the current pointer, and the array port reads the word back one cycle after the address is presented. While the direction is output, serial writes are suppressed, and `ser_dout` shows the word at the pointer one clock later.
- R12: A conventional transfer in the same cycle as `sc_en` takes priority, and the pointer loads the tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer command strobe |
| xfer_kind | input | 2 | Bit 1 = split, bit 0 = write |
| xfer_tap | input | ADDR_W | Tap address captured with the transfer |
| sc_en | input | 1 | Serial clock enable, one word per cycle |
| ser_din | input | DATA_W | Serial input word |
| ser_dout | output | DATA_W | Serial output word (registered) |
| arr_we | input | 1 | Array-side write enable |
| arr_addr | input | ADDR_W | Array-side word address |
| arr_wdata | input | DATA_W | Array-side write word |
| arr_rdata | output | DATA_W | Array-side read word (registered) |
| ptr_o | output | ADDR_W | Current pointer |
| ptr_half_o | output | 1 | Half the pointer is in |
| split_mode_o | output | 1 | 1 when split mode is active |
| ser_dir_o | output | 1 | 1 = serial output, 0 = serial input |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8. That gives a 16-word register split into halves of 8 words. With a register this small, full-register wrap, both directions of half switching, and the tap-exhaustion fallback can each be reached in a few serial steps. The default 512-word size uses the same logic with wider fields, so the same sequences cover its boundary cases.

// File: rtl/stseq_pkg.sv
package stseq_pkg;
  // Transfer command coding: bit 1 selects split, bit 0 selects write.
  typedef enum logic [1:0] {
    XK_CONV_RD  = 2'b00,
    XK_CONV_WR  = 2'b01,
    XK_SPLIT_RD = 2'b10,
    XK_SPLIT_WR = 2'b11
  } xfer_kind_e;
endpackage

// File: rtl/stseq_ctrl.sv
module stseq_ctrl #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  input  logic [1:0]        xfer_kind,
  input  logic [ADDR_W-1:0] xfer_tap,
  input  logic              sc_en,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              split_o,
  output logic              dir_out_o
);
  import stseq_pkg::*;
  localparam int LOW_W = ADDR_W - 1;

  logic [ADDR_W-1:0] ptr_q, ptr_adv;
  logic              split_q, dir_q, seen_q;
  logic              pend_vld_q;
  logic [LOW_W-1:0]  pend_tap_q;

  logic             conv_x, split_acc, at_top, tap_ok;
  logic [LOW_W-1:0] tap_low, entry_low;

  always_comb begin
    tap_low   = xfer_tap[LOW_W-1:0];
    tap_ok    = (tap_low != '1);                 // R8: last address of a half refused
    conv_x    = xfer_valid && !xfer_kind[1];
    split_acc = xfer_valid && xfer_kind[1] && seen_q && tap_ok;  // R4
    at_top    = &ptr_q[LOW_W-1:0];
    // R6/R7: entry point into the other half; same-cycle split tap wins
    if (split_acc)       entry_low = tap_low;
    else if (pend_vld_q) entry_low = pend_tap_q;
    else                 entry_low = '0;
    if (!split_q)        ptr_adv = ptr_q + 1'b1;  // R3 circular wrap
    else if (at_top)     ptr_adv = {~ptr_q[ADDR_W-1], entry_low};
    else                 ptr_adv = {ptr_q[ADDR_W-1], ptr_q[LOW_W-1:0] + 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q      <= '0;
      split_q    <= 1'b0;
      dir_q      <= 1'b0;
      seen_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_tap_q <= '0;
    end else begin
      if (conv_x) begin                          // R2, R12
        ptr_q      <= xfer_tap;
        split_q    <= 1'b0;
        dir_q      <= (xfer_kind == XK_CONV_RD);
        seen_q     <= 1'b1;
        pend_vld_q <= 1'b0;
      end else begin
        if (sc_en) ptr_q <= ptr_adv;
        if (split_acc) split_q <= 1'b1;          // R5
        if (sc_en && split_q && at_top) begin
          pend_vld_q <= 1'b0;                    // R9: tap used once
        end else if (split_acc) begin
          pend_vld_q <= 1'b1;
          pend_tap_q <= tap_low;
        end
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign split_o   = split_q;
  assign dir_out_o = dir_q;
endmodule

// File: rtl/stseq_ram.sv
module stseq_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // True dual port, read-first, registered reads.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/serial_tap_sequencer.sv
module serial_tap_sequencer #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  input  logic [1:0]        xfer_kind,
  input  logic [ADDR_W-1:0] xfer_tap,
  input  logic              sc_en,
  input  logic [DATA_W-1:0] ser_din,
  output logic [DATA_W-1:0] ser_dout,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_wdata,
  output logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              ptr_half_o,
  output logic              split_mode_o,
  output logic              ser_dir_o
);
  logic ser_we;

  stseq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .xfer_valid(xfer_valid),
    .xfer_kind (xfer_kind),
    .xfer_tap  (xfer_tap),
    .sc_en     (sc_en),
    .ptr_o     (ptr_o),
    .split_o   (split_mode_o),
    .dir_out_o (ser_dir_o)
  );

  assign ser_we     = sc_en && !ser_dir_o;       // R11
  assign ptr_half_o = ptr_o[ADDR_W-1];           // R10

  stseq_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
    .clk    (clk),
    .a_we   (arr_we),
    .a_addr (arr_addr),
    .a_wdata(arr_wdata),
    .a_rdata(arr_rdata),
    .b_we   (ser_we),
    .b_addr (ptr_o),
    .b_wdata(ser_din),
    .b_rdata(ser_dout)
  );
endmodule

// File: rtl/stseq_chk.sv
module stseq_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_valid,
  input logic [1:0]        xfer_kind,
  input logic [ADDR_W-1:0] xfer_tap,
  input logic              sc_en,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              split_mode_o,
  input logic              ser_dir_o
);
  localparam int LOW_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [LOW_W-1:0]  ONE_L = 1;

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else if (xfer_valid && !xfer_kind[1]) seen_q <= 1'b1;
  end

  p_conv_load_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_kind[1]) |=>
      (ptr_o == $past(xfer_tap)) && !split_mode_o && (ser_dir_o == !$past(xfer_kind[0])));

  p_full_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!xfer_valid && sc_en && !split_mode_o) |=> (ptr_o == $past(ptr_o) + ONE_A));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!xfer_valid && !sc_en) |=> $stable(ptr_o));

  p_early_split_r4: assert property (@(posedge clk) disable iff (rst)
    (!seen_q && xfer_valid && xfer_kind[1] && !sc_en) |=>
      ($stable(ptr_o) && $stable(split_mode_o) && $stable(ser_dir_o)));

  p_split_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_kind[1]) |=> $stable(ser_dir_o));

  p_half_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (split_mode_o && sc_en && !xfer_valid && (&ptr_o[LOW_W-1:0])) |=>
      (ptr_o[ADDR_W-1] != $past(ptr_o[ADDR_W-1])));

  p_in_half_r6: assert property (@(posedge clk) disable iff (rst)
    (split_mode_o && sc_en && !xfer_valid && !(&ptr_o[LOW_W-1:0])) |=>
      ((ptr_o[ADDR_W-1] == $past(ptr_o[ADDR_W-1])) &&
       (ptr_o[LOW_W-1:0] == $past(ptr_o[LOW_W-1:0]) + ONE_L)));
endmodule

bind serial_tap_sequencer stseq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .xfer_valid  (xfer_valid),
  .xfer_kind   (xfer_kind),
  .xfer_tap    (xfer_tap),
  .sc_en       (sc_en),
  .ptr_o       (ptr_o),
  .split_mode_o(split_mode_o),
  .ser_dir_o   (ser_dir_o)
);

// File: tb/serial_tap_sequencer_tb_top.sv
`timescale 1ns/1ps
module serial_tap_sequencer_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          xfer_valid;
  logic [1:0]    xfer_kind;
  logic [AW-1:0] xfer_tap;
  logic          sc_en;
  logic [DW-1:0] ser_din, ser_dout;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, arr_rdata;
  logic [AW-1:0] ptr_o;
  logic          ptr_half_o, split_mode_o, ser_dir_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  serial_tap_sequencer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
    .xfer_tap(xfer_tap), .sc_en(sc_en), .ser_din(ser_din), .ser_dout(ser_dout),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .ptr_o(ptr_o), .ptr_half_o(ptr_half_o), .split_mode_o(split_mode_o),
    .ser_dir_o(ser_dir_o)
  );

  typedef struct packed {
    logic       xv;
    logic [1:0] k;
    logic [3:0] tap;
    logic       sc;
    logic [3:0] ptr;
    logic       sp;
    logic       dir;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 4'd3,  1'b0, 4'd0,  1'b0, 1'b0, 8'd4},  // R4 split before conventional
    '{1'b1, 2'd0, 4'd13, 1'b0, 4'd13, 1'b0, 1'b1, 8'd2},  // R2 read transfer
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd14, 1'b0, 1'b1, 8'd3},  // R3
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd15, 1'b0, 1'b1, 8'd3},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd0,  1'b0, 1'b1, 8'd3},  // R3 wrap
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd1,  1'b0, 1'b1, 8'd3},
    '{1'b1, 2'd1, 4'd5,  1'b0, 4'd5,  1'b0, 1'b0, 8'd2},  // R2 write transfer
    '{1'b1, 2'd2, 4'd2,  1'b0, 4'd5,  1'b1, 1'b0, 8'd5},  // R5 tap 10 pending
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd6,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd7,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd10, 1'b1, 1'b0, 8'd6},  // R6 jump to tap
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd11, 1'b1, 1'b0, 8'd6},
    '{1'b1, 2'd3, 4'd7,  1'b0, 4'd11, 1'b1, 1'b0, 8'd8},  // R8 last-address tap
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd12, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd13, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd14, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd15, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd0,  1'b1, 1'b0, 8'd7},  // R7 no tap pending
    '{1'b1, 2'd3, 4'd4,  1'b1, 4'd1,  1'b1, 1'b0, 8'd5},  // R5 tap 12 pending
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd2,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd3,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd4,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd5,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd6,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd7,  1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd12, 1'b1, 1'b0, 8'd6},  // R6
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd13, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd14, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd15, 1'b1, 1'b0, 8'd6},
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd0,  1'b1, 1'b0, 8'd9},  // R9 tap used once
    '{1'b1, 2'd0, 4'd9,  1'b1, 4'd9,  1'b0, 1'b1, 8'd12}, // R12 transfer beats shift
    '{1'b0, 2'd0, 4'd0,  1'b1, 4'd10, 1'b0, 1'b1, 8'd3}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic xv, input logic [1:0] k, input logic [AW-1:0] tap,
                      input logic sc, input logic [DW-1:0] din);
    xfer_valid = xv; xfer_kind = k; xfer_tap = tap; sc_en = sc; ser_din = din;
    @(posedge clk);
    @(negedge clk);
    xfer_valid = 1'b0; sc_en = 1'b0;
  endtask

  task automatic arr_read(input logic [AW-1:0] a);
    arr_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xfer_valid = 1'b0; xfer_kind = 2'd0; xfer_tap = '0; sc_en = 1'b0;
    ser_din = '0; arr_we = 1'b0; arr_addr = '0; arr_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "ptr", int'(ptr_o), 0);
    chk("R1", "split", int'(split_mode_o), 0);
    chk("R1", "dir", int'(ser_dir_o), 0);
    chk("R1", "half", int'(ptr_half_o), 0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].xv, VECS[i].k, VECS[i].tap, VECS[i].sc, 8'h00);
      chk($sformatf("R%0d", VECS[i].req), $sformatf("ptr v%0d", i), int'(ptr_o), int'(VECS[i].ptr));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("split v%0d", i), int'(split_mode_o), int'(VECS[i].sp));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("dir v%0d", i), int'(ser_dir_o), int'(VECS[i].dir));
      chk("R10", $sformatf("half v%0d", i), int'(ptr_half_o), int'(VECS[i].ptr[3]));
    end

    // R6: split tap given in the switching cycle overrides the pending one
    step(1'b1, 2'd1, 4'd6, 1'b0, 8'h00);
    step(1'b1, 2'd2, 4'd1, 1'b0, 8'h00);   // pending 9
    step(1'b0, 2'd0, 4'd0, 1'b1, 8'h00);   // ptr 7
    chk("R6", "ptr before switch", int'(ptr_o), 7);
    step(1'b1, 2'd3, 4'd3, 1'b1, 8'h00);   // switch with tap 11
    chk("R6", "bypass tap", int'(ptr_o), 11);

    // R11 serial write in input direction
    step(1'b1, 2'd1, 4'd2, 1'b0, 8'h00);
    step(1'b0, 2'd0, 4'd0, 1'b1, 8'hA5);
    step(1'b0, 2'd0, 4'd0, 1'b1, 8'h3C);
    arr_read(4'd2);
    chk("R11", "array read word 2", int'(arr_rdata), 8'hA5);
    arr_read(4'd3);
    chk("R11", "array read word 3", int'(arr_rdata), 8'h3C);

    // R11 output direction: read out, writes suppressed
    step(1'b1, 2'd0, 4'd2, 1'b0, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R11", "serial out word 2", int'(ser_dout), 8'hA5);
    step(1'b0, 2'd0, 4'd0, 1'b1, 8'hFF);   // must not write word 2
    arr_read(4'd2);
    chk("R11", "word 2 kept in output mode", int'(arr_rdata), 8'hA5);
    chk("R11", "serial out word 3", int'(ser_dout), 8'h3C);

    // R11 array write then serial read
    arr_addr = 4'd5; arr_wdata = 8'h77; arr_we = 1'b1;
    @(posedge clk); @(negedge clk);
    arr_we = 1'b0;
    step(1'b1, 2'd0, 4'd5, 1'b0, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R11", "serial out array word", int'(ser_dout), 8'h77);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule